// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs one external machine cycle at a time on a bus whose eight low address bits and eight data bits take turns on the same byte lane. A requester hands it a 16-bit address, a cycle kind and, for writes, a data byte. The controller drives the upper address byte on its own lines and puts the lower address byte on the shared lane with a one-cycle latch strobe. It then asserts the matching active-low read or write strobe, stretches the cycle while the ready input is low, and returns read data captured from the shared lane.

Each cycle is three clock phases long: an address phase, a strobe phase in which ready is sampled, and a transfer phase, with any wait phases placed between the strobe phase and the transfer phase. An external master can take the bus with a hold request. The controller grants it only between cycles and then floats every bus output. Output enables stand in for the tri-state pad controls, so each driven group comes with its own enable.

Top module: `mc_bus_ctrl`

## Requirements
- R1: While `rst` is high and for the cycle in which it is first seen low, `rst_out` is 1 and `a_hi_oe`, `ad_oe`, `ctl_oe` and `hlda` are 0. After that the bus is idle, with `ctl_oe`=1, `rd_n`=`wr_n`=1 and `hlda`=0.
- R2: A request is taken (`req_accept`=1) only when the controller is idle or in the transfer phase and `hold` is low. In the next cycle (the address phase), `ale`=1, `a_hi`=addr[15:8], `ad_out`=addr[7:0] and `ad_oe`=1, with both strobes high. `ale` is 0 in every other cycle.
- R3: `req_kind` encodes 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write and 5 halt (6 and 7 act as halt). `st` is 11 for a fetch, 10 for a read, 01 for a write and 00 for a halt. `io_m` is 1 for the I/O kinds and 0 for the rest.
- R4: For fetch and read kinds, `rd_n` is low from the strobe phase through the transfer phase and `ad_oe` is 0 after the address phase. The shared-lane value at the end of the transfer phase appears on `rd_data` in the following cycle, with `rd_valid`=1 for exactly that one cycle.
- R5: For write kinds, `wr_n` is low from the strobe phase through the transfer phase, and `ad_out` holds the write byte with `ad_oe`=1 over the same span.
- R6: Each sample of `ready` low at the end of the strobe phase or of a wait phase adds one wait phase, during which the active strobe stays low and `ale` stays 0.
- R7: A `hold` that arrives mid-cycle does not cut the cycle short. In the cycle after the transfer phase (or after an idle cycle with `hold` high), `hlda`=1 and all output enables are 0, and no request is accepted.
- R8: In the cycle after `hold` is seen low in the granted state, `hlda` returns to 0, the bus is driven again and a pending request is accepted.
- R9: A halt cycle drives status 00 and never asserts a strobe or the shared lane after its address phase. It ignores `ready`, so its transfer phase falls two cycles after the address phase.
- R10: `rd_n` and `wr_n` are never low together.
- R11: A request presented during the transfer phase starts its address phase in the very next cycle, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cycle request present |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| ready | input | 1 | Slave ready; low stretches the cycle |
| hold | input | 1 | External master bus request |
| ad_in | input | 8 | Shared lane as seen at the pads |
| req_accept | output | 1 | Request taken this cycle |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |
| a_hi | output | 8 | Upper address byte |
| a_hi_oe | output | 1 | Drive enable for `a_hi` |
| ad_out | output | 8 | Shared lane drive value |
| ad_oe | output | 1 | Drive enable for the shared lane |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for I/O, 0 for memory |
| st | output | 2 | Cycle status code |
| ctl_oe | output | 1 | Drive enable for strobes and status |
| hlda | output | 1 | Hold grant |
| rst_out | output | 1 | Reset in progress |

## Verification
The bench goes after the cycle-length edges. With zero, one and three wait phases, a controller that miscounted ready samples would release its strobe early or hold it one phase too long, and the data check at the transfer phase would then fail. A halt issued with `ready` low must not stall: a controller that waited on ready for it would refuse the back-to-back request offered in its transfer phase. Hold raised in the middle of a read catches a controller that floats the bus before its transfer phase, and also one that still accepts a request while granted. A request presented during a transfer phase catches a controller that inserts an idle cycle between cycles, or that loses the read pulse of the cycle that is ending.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_FETCH = 3'd0,
        K_MRD   = 3'd1,
        K_MWR   = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4,
        K_HALT  = 3'd5
    } kind_e;

    typedef enum logic [2:0] {
        P_RST, P_IDLE, P_T1, P_T2, P_TW, P_T3, P_HOLD
    } phase_e;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    function automatic logic kind_reads(input logic [KIND_W-1:0] k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
    endfunction

    function automatic logic kind_writes(input logic [KIND_W-1:0] k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

    function automatic logic kind_io(input logic [KIND_W-1:0] k);
        return (k == K_IORD) || (k == K_IOWR);
    endfunction

    function automatic logic [1:0] kind_status(input logic [KIND_W-1:0] k);
        logic [1:0] s;
        case (k)
            K_FETCH:       s = 2'b11;
            K_MRD, K_IORD: s = 2'b10;
            K_MWR, K_IOWR: s = 2'b01;
            default:       s = 2'b00;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
    import mbc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  req_t   req,
    input  logic   ready,
    input  logic   hold,
    output phase_e phase,
    output req_t   cur,
    output logic   accept,
    output logic   cap_en
);
    phase_e nxt;
    logic   waits;

    assign waits  = kind_reads(cur.kind) || kind_writes(cur.kind);
    assign accept = ((phase == P_IDLE) || (phase == P_T3)) && req_valid && !hold && !rst;
    assign cap_en = (phase == P_T3) && kind_reads(cur.kind);

    always_comb begin
        nxt = phase;
        case (phase)
            P_RST:  nxt = P_IDLE;
            P_IDLE: if (hold) nxt = P_HOLD; else if (accept) nxt = P_T1;
            P_T1:   nxt = P_T2;
            P_T2:   nxt = (!waits || ready) ? P_T3 : P_TW;
            P_TW:   nxt = ready ? P_T3 : P_TW;
            P_T3:   if (hold) nxt = P_HOLD; else if (accept) nxt = P_T1; else nxt = P_IDLE;
            P_HOLD: nxt = hold ? P_HOLD : P_IDLE;
            default: nxt = P_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= P_RST;
            cur.kind  <= K_HALT;
            cur.addr  <= '0;
            cur.wdata <= '0;
        end else begin
            phase <= nxt;
            if (accept) cur <= req;
        end
    end

    // R6: a low ready in a wait phase keeps the cycle stretched
    a_r6_wait_stays: assert property (@(posedge clk) disable iff (rst)
        (phase == P_TW && !ready) |=> (phase == P_TW));
    // R11: request in transfer phase starts the next address phase at once
    a_r11_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (phase == P_T3 && req_valid && !hold) |=> (phase == P_T1));
    // R8: grant is withdrawn one cycle after hold drops
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (phase == P_HOLD && !hold) |=> (phase == P_IDLE));
    // R7: hold never interrupts a cycle in its strobe phase
    a_r7_no_cut: assert property (@(posedge clk) disable iff (rst)
        (phase == P_T2 && hold) |=> (phase != P_HOLD));
endmodule

// File: rtl/mbc_drive.sv
module mbc_drive
    import mbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  req_t              cur,
    output logic [HI_W-1:0]   a_hi,
    output logic              a_hi_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m,
    output logic [1:0]        st,
    output logic              ctl_oe,
    output logic              hlda,
    output logic              rst_out
);
    logic bus_on;
    logic strobe_ph;

    assign bus_on    = (phase != P_RST) && (phase != P_HOLD);
    assign strobe_ph = (phase == P_T2) || (phase == P_TW) || (phase == P_T3);

    assign a_hi    = cur.addr[ADDR_W-1 -: HI_W];
    assign a_hi_oe = bus_on;
    assign ctl_oe  = bus_on;
    assign ale     = (phase == P_T1);
    assign ad_oe   = (phase == P_T1) || (strobe_ph && kind_writes(cur.kind));
    assign ad_out  = (phase == P_T1) ? cur.addr[DATA_W-1:0] : cur.wdata;
    assign rd_n    = !(strobe_ph && kind_reads(cur.kind));
    assign wr_n    = !(strobe_ph && kind_writes(cur.kind));
    assign io_m    = bus_on && kind_io(cur.kind);
    assign st      = bus_on ? kind_status(cur.kind) : 2'b00;
    assign hlda    = (phase == P_HOLD);
    assign rst_out = (phase == P_RST);

    // R10: strobes mutually exclusive
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));
    // R7: granted bus is fully floated
    a_r7_float: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (!ad_oe && !ctl_oe && !a_hi_oe));
    // R2: the latch strobe marks a driven address with idle strobes
    a_r2_ale_addr: assert property (@(posedge clk) disable iff (rst)
        ale |-> (ad_oe && rd_n && wr_n));
endmodule

// File: rtl/mbc_capture.sv
module mbc_capture
    import mbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= cap_en;
            if (cap_en) rd_data <= ad_in;
        end
    end

    // R4: the read pulse lasts one cycle
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/mc_bus_ctrl.sv
module mc_bus_ctrl
    import mbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    input  logic              hold,
    input  logic [DATA_W-1:0] ad_in,
    output logic              req_accept,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [HI_W-1:0]   a_hi,
    output logic              a_hi_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m,
    output logic [1:0]        st,
    output logic              ctl_oe,
    output logic              hlda,
    output logic              rst_out
);
    req_t   req;
    req_t   cur;
    phase_e phase;
    logic   cap_en;

    assign req.kind  = req_kind;
    assign req.addr  = req_addr;
    assign req.wdata = req_wdata;

    mbc_seq u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req(req),
        .ready(ready), .hold(hold), .phase(phase), .cur(cur),
        .accept(req_accept), .cap_en(cap_en)
    );

    mbc_drive u_drive (
        .clk(clk), .rst(rst), .phase(phase), .cur(cur),
        .a_hi(a_hi), .a_hi_oe(a_hi_oe), .ad_out(ad_out), .ad_oe(ad_oe),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .st(st),
        .ctl_oe(ctl_oe), .hlda(hlda), .rst_out(rst_out)
    );

    mbc_capture u_cap (
        .clk(clk), .rst(rst), .cap_en(cap_en), .ad_in(ad_in),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: tb/sim_mc_bus_ctrl.sv
module sim_mc_bus_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0] req_wdata = 8'h0;
    logic       ready = 1'b1;
    logic       hold = 1'b0;
    logic [7:0] ad_in = 8'h0;
    logic       req_accept, rd_valid, a_hi_oe, ad_oe, ale, rd_n, wr_n, io_m, ctl_oe, hlda, rst_out;
    logic [7:0] rd_data, a_hi, ad_out;
    logic [1:0] st;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mc_bus_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .hold(hold),
        .ad_in(ad_in), .req_accept(req_accept), .rd_data(rd_data), .rd_valid(rd_valid),
        .a_hi(a_hi), .a_hi_oe(a_hi_oe), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .st(st), .ctl_oe(ctl_oe),
        .hlda(hlda), .rst_out(rst_out)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_st(input logic [2:0] k);
        case (k)
            3'd0: return 2'b11;
            3'd1, 3'd3: return 2'b10;
            3'd2, 3'd4: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic is_rd(input logic [2:0] k);
        return k == 3'd0 || k == 3'd1 || k == 3'd3;
    endfunction

    function automatic logic is_wr(input logic [2:0] k);
        return k == 3'd2 || k == 3'd4;
    endfunction

    // present a request at this negedge and check it is taken (R2)
    task automatic offer(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
        #0;
        chk("R2 accept", {15'd0, req_accept}, 16'd1);
    endtask

    // at the address-phase negedge
    task automatic check_t1(input logic [2:0] k, input logic [15:0] a);
        chk("R2 ale", {15'd0, ale}, 16'd1);
        chk("R2 addr", {a_hi, ad_out}, a);
        chk("R2 ad_oe", {15'd0, ad_oe}, 16'd1);
        chk("R2 strobes idle", {14'd0, rd_n, wr_n}, 16'd3);
        chk("R3 status", {14'd0, st}, {14'd0, exp_st(k)});
        chk("R3 io_m", {15'd0, io_m}, {15'd0, (k == 3'd3 || k == 3'd4)});
    endtask

    task automatic check_strobe(input logic [2:0] k, input logic [7:0] wd, input string tag);
        chk({tag, " ale low"}, {15'd0, ale}, 16'd0);
        chk({tag, " rd_n"}, {15'd0, rd_n}, {15'd0, !is_rd(k)});
        chk({tag, " wr_n"}, {15'd0, wr_n}, {15'd0, !is_wr(k)});
        chk({tag, " ad_oe"}, {15'd0, ad_oe}, {15'd0, is_wr(k)});
        if (is_wr(k)) chk("R5 wdata", {8'd0, ad_out}, {8'd0, wd});
    endtask

    // full cycle starting at an idle negedge; ends at the negedge after the transfer phase
    task automatic run_cycle(input logic [2:0] k, input logic [15:0] a, input logic [7:0] wd,
                             input int nwait, input logic [7:0] rdat);
        offer(k, a, wd);
        @(negedge clk);
        req_valid = 1'b0;
        check_t1(k, a);
        ready = (nwait == 0);
        @(negedge clk);
        check_strobe(k, wd, is_wr(k) ? "R5 T2" : "R4 T2");
        for (int w = 0; w < nwait; w++) begin
            @(negedge clk);
            check_strobe(k, wd, "R6 wait");
            if (w == nwait - 1) ready = 1'b1;
        end
        ad_in = rdat;
        @(negedge clk);
        check_strobe(k, wd, "R4/R5 T3");
        @(negedge clk);
        chk("R4 strobes released", {14'd0, rd_n, wr_n}, 16'd3);
        chk("R4 rd_valid", {15'd0, rd_valid}, {15'd0, is_rd(k)});
        if (is_rd(k)) chk("R4 rd_data", {8'd0, rd_data}, {8'd0, rdat});
        ad_in = 8'h00;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 rst_out", {15'd0, rst_out}, 16'd1);
        chk("R1 enables off", {13'd0, a_hi_oe, ad_oe, ctl_oe}, 16'd0);
        chk("R1 hlda", {15'd0, hlda}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rst_out released", {15'd0, rst_out}, 16'd0);
        chk("R1 bus driven", {15'd0, ctl_oe}, 16'd1);
        chk("R1 strobes high", {14'd0, rd_n, wr_n}, 16'd3);
        chk("R1 ale low", {15'd0, ale}, 16'd0);
    endtask

    task automatic t_basic;
        run_cycle(3'd0, 16'h2005, 8'h00, 0, 8'h4F);
        run_cycle(3'd1, 16'hA15C, 8'h00, 1, 8'hC3);
        run_cycle(3'd2, 16'h1234, 8'h9A, 0, 8'h00);
        run_cycle(3'd3, 16'h00F7, 8'h00, 3, 8'h5A);
        run_cycle(3'd4, 16'hFF01, 8'h66, 2, 8'h00);
    endtask

    // R9: halt ignores ready and is done two cycles after the address phase
    task automatic t_halt;
        offer(3'd5, 16'h7788, 8'h00);
        @(negedge clk);
        req_valid = 1'b0;
        check_t1(3'd5, 16'h7788);
        ready = 1'b0;
        @(negedge clk);
        chk("R9 no strobe T2", {13'd0, rd_n, wr_n, ad_oe}, 16'd6);
        @(negedge clk);
        chk("R9 no strobe T3", {13'd0, rd_n, wr_n, ad_oe}, 16'd6);
        offer(3'd0, 16'h0100, 8'h00);
        ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 next ale", {15'd0, ale}, 16'd1);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R9 fetch done", {15'd0, rd_valid}, 16'd1);
    endtask

    // R11: request during transfer phase, next cycle is the address phase
    task automatic t_b2b;
        offer(3'd1, 16'h3344, 8'h00);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        ad_in = 8'hE1;
        @(negedge clk);
        chk("R11 T3 rd_n", {15'd0, rd_n}, 16'd0);
        offer(3'd2, 16'h5566, 8'h77);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 immediate ale", {15'd0, ale}, 16'd1);
        chk("R11 addr", {a_hi, ad_out}, 16'h5566);
        chk("R11 prior read", {7'd0, rd_valid, rd_data}, 16'h01E1);
        @(negedge clk);
        chk("R11 write strobe", {15'd0, wr_n}, 16'd0);
        @(negedge clk);
        @(negedge clk);
        chk("R11 idle", {15'd0, wr_n}, 16'd1);
    endtask

    // R7/R8: hold mid-cycle, then release
    task automatic t_hold;
        offer(3'd1, 16'hBEEF, 8'h00);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        hold = 1'b1;
        chk("R7 T2 still driven", {15'd0, ctl_oe}, 16'd1);
        ad_in = 8'h3C;
        @(negedge clk);
        chk("R7 T3 completes", {14'd0, rd_n, hlda}, 16'd0);
        req_valid = 1'b1; req_kind = 3'd0; req_addr = 16'h0042;
        @(negedge clk);
        chk("R7 hlda", {15'd0, hlda}, 16'd1);
        chk("R7 floated", {13'd0, a_hi_oe, ad_oe, ctl_oe}, 16'd0);
        chk("R7 no accept", {15'd0, req_accept}, 16'd0);
        chk("R7 read delivered", {7'd0, rd_valid, rd_data}, 16'h013C);
        @(negedge clk);
        chk("R7 hlda held", {15'd0, hlda}, 16'd1);
        hold = 1'b0;
        @(negedge clk);
        chk("R8 hlda low", {15'd0, hlda}, 16'd0);
        chk("R8 bus back", {14'd0, ctl_oe, a_hi_oe}, 16'd3);
        chk("R8 accept", {15'd0, req_accept}, 16'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 ale", {15'd0, ale}, 16'd1);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        // idle hold grant
        hold = 1'b1;
        @(negedge clk);
        chk("R7 idle grant", {15'd0, hlda}, 16'd1);
        hold = 1'b0;
        @(negedge clk);
        chk("R8 idle release", {15'd0, hlda}, 16'd0);
    endtask

    // R10: strobes never both low, sampled each negedge
    always @(negedge clk) begin
        if (!rst && !rd_n && !wr_n) begin
            n_chk++;
            n_bad++;
            $display("FAIL R10 actual rd_n=0 wr_n=0 expected not both low");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_halt();
        @(negedge clk);
        t_b2b();
        t_hold();
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule